// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block decides, in the decode stage of a five-stage in-order pipeline, whether the instruction now being decoded must wait one cycle because the instruction just ahead of it is a load whose result it reads. When it waits, fetch stops, the decode register keeps its contents, and an empty control word goes into the execute stage. The load ahead keeps moving down the pipe. On the next cycle the loaded value is one stage further on and can be forwarded, so the held instruction goes ahead with no second wait.

The hazard logic is packaged with a small model of the PC and the IF/ID, ID/EX and EX/MEM registers. Its stall behaviour can then be seen over several cycles at the ports. A test drives decoded fetch fields chosen by the current PC value. Forwarding, branches and memory are not modelled.

Top module: `lus_load_use_unit`

## Requirements
- R1: A stall is raised when ID/EX holds a load (its memory-read control bit is 1) with a nonzero destination rt, and that rt equals the IF/ID rs field.
- R2: An rt-field match also raises a stall, but only when the decoding instruction's uses-rt flag is 1; with the flag at 0 an rt match alone does not stall.
- R3: A load whose destination rt is register 0 never raises a stall, even when the register fields match.
- R4: An instruction in ID/EX whose memory-read bit is 0 never raises a stall, whatever its rt field.
- R5: While stalled, pc_we and ifid_we are 0 and bubble is 1. In every other cycle pc_we and ifid_we are 1 and bubble is 0.
- R6: On the clock edge that ends a stalled cycle, ID/EX loads an empty entry: tag 0, memory-read 0, register-write 0.
- R7: On that same edge the PC and the IF/ID entry keep their values. The held instruction reaches ID/EX on the following edge.
- R8: On that same edge the load moves from ID/EX into EX/MEM with its memory-read bit still 1.
- R9: Each load-use dependence costs exactly one stall cycle, including a chain of a load feeding a load that in turn feeds its consumer.
- R10: With synchronous reset held, the PC reads 0 and the IF/ID, ID/EX and EX/MEM entries are empty (tag 0, all control bits 0). Without a stall the PC increments by 1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_tag | input | 8 | Identifier of the fetched instruction (0 means empty) |
| fetch_rs | input | 5 | First source register of the fetched instruction |
| fetch_rt | input | 5 | Second source register, or load destination |
| fetch_uses_rt | input | 1 | Fetched instruction reads its rt register |
| fetch_mem_read | input | 1 | Fetched instruction is a load |
| fetch_reg_write | input | 1 | Fetched instruction writes a register |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | IF/ID write enable |
| bubble | output | 1 | Clears control fields entering ID/EX |
| pc_q | output | 8 | Current PC (instruction index) |
| id_tag | output | 8 | Tag held in IF/ID |
| ex_tag | output | 8 | Tag held in ID/EX |
| ex_mem_read | output | 1 | Memory-read bit held in ID/EX |
| ex_reg_write | output | 1 | Register-write bit held in ID/EX |
| mem_tag | output | 8 | Tag held in EX/MEM |
| mem_mem_read | output | 1 | Memory-read bit held in EX/MEM |

## Verification
The three enables are combinational. They depend on what IF/ID and ID/EX hold, so they are read in the same cycle, between edges, after the edge that brought the load and its consumer together. The PC, ID/EX and EX/MEM contents each sit behind one register, so their effect is read after the edge that closes the stalled cycle. The bench moves one edge at a time and samples on the falling edge. It compares each cycle with a hand-worked row holding the expected stall flag, ID/EX tag and PC. The EX/MEM tag is expected to equal the previous row's ID/EX tag.

// File: rtl/lus_pkg.sv
package lus_pkg;

    localparam int REG_W  = 5;
    localparam int PC_W   = 8;
    localparam int TAG_W  = 8;
    localparam int N_SRC  = 2;
    localparam int ALUOP_W = 2;

    typedef struct packed {
        logic               mem_read;
        logic               mem_write;
        logic               reg_write;
        logic               mem_to_reg;
        logic               alu_src;
        logic [ALUOP_W-1:0] alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic             uses_rt;
        ctrl_t            ctrl;
    } instr_t;

    localparam ctrl_t  CTRL_NOP  = '0;
    localparam instr_t INSTR_NOP = '0;

    function automatic logic dest_is_live(input logic [REG_W-1:0] r);
        return r != '0;
    endfunction

    function automatic instr_t squash(input instr_t i);
        instr_t o;
        o = INSTR_NOP;
        o.tag = '0;
        return o;
    endfunction

endpackage

// File: rtl/lus_hazard_detect.sv
module lus_hazard_detect
    import lus_pkg::*;
(
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] ex_dest,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_uses_rt,
    output logic             stall
);
    logic [N_SRC-1:0][REG_W-1:0] src_reg;
    logic [N_SRC-1:0]            src_used;
    logic [N_SRC-1:0]            hit;

    always_comb begin
        src_reg[0]  = id_rs;
        src_used[0] = 1'b1;
        src_reg[1]  = id_rt;
        src_used[1] = id_uses_rt;
    end

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src_cmp
            assign hit[g] = src_used[g] && (src_reg[g] == ex_dest);
        end
    endgenerate

    assign stall = ex_is_load && dest_is_live(ex_dest) && (|hit);

endmodule

// File: rtl/lus_stall_ctrl.sv
module lus_stall_ctrl (
    input  logic stall,
    output logic pc_we,
    output logic ifid_we,
    output logic bubble
);
    always_comb begin
        pc_we   = !stall;
        ifid_we = !stall;
        bubble  = stall;
    end
endmodule

// File: rtl/lus_pipe_regs.sv
module lus_pipe_regs
    import lus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_we,
    input  logic            ifid_we,
    input  logic            bubble,
    input  instr_t          fetched,
    output logic [PC_W-1:0] pc_q,
    output instr_t          ifid_q,
    output instr_t          idex_q,
    output instr_t          exmem_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (pc_we) begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ifid_q <= INSTR_NOP;
        end else if (ifid_we) begin
            ifid_q <= fetched;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q <= INSTR_NOP;
        end else if (bubble) begin
            idex_q <= squash(ifid_q);
        end else begin
            idex_q <= ifid_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exmem_q <= INSTR_NOP;
        end else begin
            exmem_q <= idex_q;
        end
    end

    AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        bubble |=> (idex_q.ctrl == CTRL_NOP && idex_q.tag == '0)); // R6

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc_q)); // R7

    AST_IFID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ifid_we |=> $stable(ifid_q)); // R7

    AST_LOAD_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (bubble && idex_q.ctrl.mem_read) |=> exmem_q.ctrl.mem_read); // R8

endmodule

// File: rtl/lus_load_use_unit.sv
module lus_load_use_unit
    import lus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       fetch_tag,
    input  logic [4:0]       fetch_rs,
    input  logic [4:0]       fetch_rt,
    input  logic             fetch_uses_rt,
    input  logic             fetch_mem_read,
    input  logic             fetch_reg_write,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             bubble,
    output logic [7:0]       pc_q,
    output logic [7:0]       id_tag,
    output logic [7:0]       ex_tag,
    output logic             ex_mem_read,
    output logic             ex_reg_write,
    output logic [7:0]       mem_tag,
    output logic             mem_mem_read
);
    instr_t fetched;
    instr_t ifid_q;
    instr_t idex_q;
    instr_t exmem_q;
    logic   stall;

    always_comb begin
        fetched                 = INSTR_NOP;
        fetched.tag             = fetch_tag;
        fetched.rs              = fetch_rs;
        fetched.rt              = fetch_rt;
        fetched.uses_rt         = fetch_uses_rt;
        fetched.ctrl.mem_read   = fetch_mem_read;
        fetched.ctrl.mem_to_reg = fetch_mem_read;
        fetched.ctrl.alu_src    = fetch_mem_read;
        fetched.ctrl.reg_write  = fetch_reg_write;
    end

    lus_hazard_detect u_detect (
        .ex_is_load (idex_q.ctrl.mem_read),
        .ex_dest    (idex_q.rt),
        .id_rs      (ifid_q.rs),
        .id_rt      (ifid_q.rt),
        .id_uses_rt (ifid_q.uses_rt),
        .stall      (stall)
    );

    lus_stall_ctrl u_ctrl (
        .stall   (stall),
        .pc_we   (pc_we),
        .ifid_we (ifid_we),
        .bubble  (bubble)
    );

    lus_pipe_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .pc_we   (pc_we),
        .ifid_we (ifid_we),
        .bubble  (bubble),
        .fetched (fetched),
        .pc_q    (pc_q),
        .ifid_q  (ifid_q),
        .idex_q  (idex_q),
        .exmem_q (exmem_q)
    );

    assign id_tag       = ifid_q.tag;
    assign ex_tag       = idex_q.tag;
    assign ex_mem_read  = idex_q.ctrl.mem_read;
    assign ex_reg_write = idex_q.ctrl.reg_write;
    assign mem_tag      = exmem_q.tag;
    assign mem_mem_read = exmem_q.ctrl.mem_read;

    AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        bubble |=> !bubble); // R9

    AST_ZERO_DEST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (idex_q.rt == '0) |-> !bubble); // R3

    AST_NONLOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !idex_q.ctrl.mem_read |-> pc_we); // R4

endmodule

// File: tb/test_lus_load_use_unit.sv
module test_lus_load_use_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fetch_tag;
    logic [4:0] fetch_rs, fetch_rt;
    logic       fetch_uses_rt, fetch_mem_read, fetch_reg_write;
    logic       pc_we, ifid_we, bubble;
    logic [7:0] pc_q, id_tag, ex_tag, mem_tag;
    logic       ex_mem_read, ex_reg_write, mem_mem_read;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lus_load_use_unit i_lus_load_use_unit (
        .clk(clk), .rst(rst),
        .fetch_tag(fetch_tag), .fetch_rs(fetch_rs), .fetch_rt(fetch_rt),
        .fetch_uses_rt(fetch_uses_rt), .fetch_mem_read(fetch_mem_read),
        .fetch_reg_write(fetch_reg_write),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble), .pc_q(pc_q),
        .id_tag(id_tag), .ex_tag(ex_tag), .ex_mem_read(ex_mem_read),
        .ex_reg_write(ex_reg_write), .mem_tag(mem_tag), .mem_mem_read(mem_mem_read)
    );

    // Program: {rs, rt, uses_rt, load}; the tag of slot p is p+1.
    function automatic logic [11:0] prog(input logic [7:0] p);
        case (p)
            8'd0:  prog = {5'd2,  5'd3,  1'b1, 1'b0};
            8'd1:  prog = {5'd3,  5'd5,  1'b0, 1'b1}; // rs matches non-load rt: R4
            8'd2:  prog = {5'd5,  5'd6,  1'b1, 1'b0}; // rs use: R1
            8'd3:  prog = {5'd0,  5'd7,  1'b0, 1'b1};
            8'd4:  prog = {5'd1,  5'd7,  1'b1, 1'b0}; // rt use: R2
            8'd5:  prog = {5'd0,  5'd8,  1'b0, 1'b1};
            8'd6:  prog = {5'd2,  5'd8,  1'b0, 1'b0}; // rt not read: R2
            8'd7:  prog = {5'd0,  5'd0,  1'b0, 1'b1};
            8'd8:  prog = {5'd0,  5'd0,  1'b1, 1'b0}; // r0: R3
            8'd9:  prog = {5'd0,  5'd9,  1'b0, 1'b1};
            8'd10: prog = {5'd0,  5'd0,  1'b0, 1'b0};
            8'd11: prog = {5'd9,  5'd0,  1'b0, 1'b0}; // not adjacent: R4
            8'd12: prog = {5'd0,  5'd10, 1'b0, 1'b1};
            8'd13: prog = {5'd10, 5'd11, 1'b0, 1'b1}; // load feeds load: R9
            8'd14: prog = {5'd11, 5'd0,  1'b0, 1'b0};
            default: prog = 12'd0;
        endcase
    endfunction

    function automatic logic tag_is_load(input logic [7:0] t);
        if (t == 8'd0) return 1'b0;
        return prog(t - 8'd1)[0];
    endfunction

    always_comb begin
        logic [11:0] w;
        w = prog(pc_q);
        fetch_rs        = w[11:7];
        fetch_rt        = w[6:2];
        fetch_uses_rt   = w[1];
        fetch_mem_read  = w[0];
        fetch_reg_write = 1'b1;
        fetch_tag       = pc_q + 8'd1;
    end

    // Per edge after reset: {stall, ex_tag, pc}
    localparam int NV = 21;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'd0,  8'd1},  {1'b0, 8'd1,  8'd2},  {1'b1, 8'd2,  8'd3},
        {1'b0, 8'd0,  8'd3},  {1'b0, 8'd3,  8'd4},  {1'b1, 8'd4,  8'd5},
        {1'b0, 8'd0,  8'd5},  {1'b0, 8'd5,  8'd6},  {1'b0, 8'd6,  8'd7},
        {1'b0, 8'd7,  8'd8},  {1'b0, 8'd8,  8'd9},  {1'b0, 8'd9,  8'd10},
        {1'b0, 8'd10, 8'd11}, {1'b0, 8'd11, 8'd12}, {1'b0, 8'd12, 8'd13},
        {1'b1, 8'd13, 8'd14}, {1'b0, 8'd0,  8'd14}, {1'b1, 8'd14, 8'd15},
        {1'b0, 8'd0,  8'd15}, {1'b0, 8'd15, 8'd16}, {1'b0, 8'd16, 8'd17}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] prev_ex;
        @(negedge clk);
        step(); step(); step();
        // R10 reset state
        check("R10 pc", pc_q, 0);
        check("R10 id_tag", id_tag, 0);
        check("R10 ex_tag", ex_tag, 0);
        check("R10 mem_tag", mem_tag, 0);
        check("R5 pc_we idle", pc_we, 1);
        rst = 1'b0;
        prev_ex = 8'd0;
        for (int n = 0; n < NV; n++) begin
            step();
            check("R1/R2/R3/R4/R9 stall", bubble, VEC[n][16]);
            check("R5 pc_we", pc_we, !VEC[n][16]);
            check("R5 ifid_we", ifid_we, !VEC[n][16]);
            check("R6/R7 ex_tag", ex_tag, VEC[n][15:8]);
            check("R6 ex_mem_read", ex_mem_read, tag_is_load(VEC[n][15:8]));
            check("R6 ex_reg_write", ex_reg_write, VEC[n][15:8] != 0);
            check("R7/R10 pc", pc_q, VEC[n][7:0]);
            check("R8 mem_tag", mem_tag, prev_ex);
            check("R8 mem_mem_read", mem_mem_read, tag_is_load(prev_ex));
            prev_ex = VEC[n][15:8];
        end
        // Directed: reset mid-run clears everything (R10)
        rst = 1'b1;
        step();
        check("R10 rerun pc", pc_q, 0);
        check("R10 rerun ex_tag", ex_tag, 0);
        check("R10 rerun mem_tag", mem_tag, 0);
        check("R10 rerun id_tag", id_tag, 0);
        check("R5 rerun bubble", bubble, 0);
        rst = 1'b0;
        step();
        check("R10 pc increments", pc_q, 1);
        check("R10 id_tag first", id_tag, 1);
        step(); step();
        // ID holds slot 2 (rs 5), EX holds slot 1 load to r5: R1 stall
        check("R1 restart stall", bubble, 1);
        check("R7 held id_tag", id_tag, 3);
        step();
        check("R7 id still held", id_tag, 3);
        check("R9 no second stall", bubble, 0);
        check("R8 load in mem", mem_tag, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule